// File: doc/BRIEF.md
# Multi-Rank Request Scheduler with Completion

This block sits in one memory controller between the request path from the host side and sixteen rank engines. Each incoming request carries a unique tag, a target rank and a read/write flag. The block enters it in a per-tag scoreboard and appends its tag to an age-ordered active list. Every cycle it sends at most one waiting request to a rank that is currently idle. It picks the oldest request that is ready to go, so a request stuck behind a busy rank does not hold back younger work bound for idle ranks.

Write payloads are not carried. An input only signals that a tag's store data has fully arrived. Completions toward the host come out on a single registered port. Reads complete after the rank engine reports the operation finished. Writes complete either when their data has arrived (early policy) or when the rank has finished the array write (late policy), chosen per request by a run-time mode input sampled at acceptance. A tag stays outstanding until its rank reports done, whichever policy applies.

Top module: `rank_req_sched`

## Requirements
- R1: A request is accepted when `reqValid` is high and its tag is not outstanding. A request whose tag is outstanding is dropped: `reqErr` pulses in the following cycle, and the request never dispatches or completes. A tag being released by a done in the same cycle still counts as outstanding.
- R2: Waiting requests are dispatched oldest first among those that are eligible, so two requests to the same rank leave in arrival order.
- R3: A rank holds one request at a time. A request to a busy rank waits, while a younger request to an idle rank dispatches ahead of it.
- R4: A read is eligible at once. A write is eligible only after `dataValid` has been seen for its tag.
- R5: A read accepted in cycle t, with its rank idle and nothing older eligible, shows `dispValid` in cycle t+2. A write whose data indication arrives in cycle d shows `dispValid` in cycle d+2. At most one dispatch occurs per cycle.
- R6: A `doneValid` for a busy rank in cycle k frees that rank and the tag held on it. For a read it raises `cmplValid` with that tag in cycle k+1. The tag may be reused from cycle k+1.
- R7: A write accepted with `earlyMode` low completes only in the cycle after its rank's done, and never when its data arrives.
- R8: A write accepted with `earlyMode` high completes two cycles after its data indication. It produces no second completion at done. Its tag stays outstanding until done. Later changes of `earlyMode` do not affect it.
- R9: When a done-driven completion and a pending early completion fall in the same cycle, the done-driven one is reported first and the early one follows in the next free cycle. An early completion still pending at done is reported at done instead.
- R10: A `doneValid` for an idle rank, and a `dataValid` for a tag that is not outstanding, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| earlyMode | input | 1 | Write completion policy sampled at acceptance: 1 early, 0 late |
| reqValid | input | 1 | New request present |
| reqTag | input | 6 | Request tag |
| reqRank | input | 4 | Target rank |
| reqWrite | input | 1 | 1 write, 0 read |
| reqErr | output | 1 | Pulse: previous cycle's request had an outstanding tag |
| dataValid | input | 1 | All store data for `dataTag` has arrived |
| dataTag | input | 6 | Tag whose write data arrived |
| doneValid | input | 1 | A rank engine finished its operation |
| doneRank | input | 4 | Rank reporting done |
| dispValid | output | 1 | Request sent to a rank this cycle |
| dispTag | output | 6 | Tag of the dispatched request |
| dispRank | output | 4 | Rank receiving it |
| dispWrite | output | 1 | Dispatched request is a write |
| cmplValid | output | 1 | Completion notification |
| cmplTag | output | 6 | Tag being completed |

## Verification
The completion port is shared, so a rank's done and an early write completion can both claim it in one cycle. The bench provokes this by giving a write its data indication one cycle before a different rank reports done. It then expects the read's tag one cycle after the done and the write's tag in the cycle after that. A second collision puts a duplicate-tag request in the cycle right after a valid request. The bench judges this by seeing the error pulse and the first request's dispatch appear together, with no dispatch for the duplicate afterwards.

// File: rtl/sched_pkg.sv
package sched_pkg;
  // Strobes from the control into the active-list datapath
  typedef struct packed {
    logic push;   // append the tag on pushTag at the tail
    logic pop;    // remove the entry at popIdx and close the hole
  } listStrobe_t;
endpackage

// File: rtl/sched_list.sv
module sched_list
  import sched_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  listStrobe_t                   strobe,
  input  logic [TAG_W-1:0]              pushTag,
  input  logic [IDX_W-1:0]              popIdx,
  output logic [DEPTH-1:0][TAG_W-1:0]   entries,
  output logic [CNT_W-1:0]              count
);
  logic [CNT_W-1:0] wrIdx;
  assign wrIdx = count - CNT_W'(strobe.pop);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [TAG_W-1:0] shifted;
    if (i < DEPTH - 1) begin : g_mid
      assign shifted = (strobe.pop && IDX_W'(i) >= popIdx) ? entries[i+1] : entries[i];
    end else begin : g_last
      assign shifted = entries[i];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)                                  entries[i] <= '0;
      else if (strobe.push && wrIdx == CNT_W'(i))  entries[i] <= pushTag;
      else                                         entries[i] <= shifted;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count - CNT_W'(strobe.pop) + CNT_W'(strobe.push);
  end

  assert_push_room_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.push |-> (count < CNT_W'(DEPTH) || strobe.pop));
  assert_pop_inside_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.pop |-> (CNT_W'(popIdx) < count));
endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int RANK_W = 4,
  localparam int DEPTH  = 1 << TAG_W,
  localparam int RANKS  = 1 << RANK_W,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        earlyMode,
  input  logic                        reqValid,
  input  logic [TAG_W-1:0]            reqTag,
  input  logic [RANK_W-1:0]           reqRank,
  input  logic                        reqWrite,
  input  logic                        dataValid,
  input  logic [TAG_W-1:0]            dataTag,
  input  logic                        doneValid,
  input  logic [RANK_W-1:0]           doneRank,
  input  logic [DEPTH-1:0][TAG_W-1:0] entries,
  input  logic [CNT_W-1:0]            count,
  output listStrobe_t                 strobe,
  output logic [IDX_W-1:0]            popIdx,
  output logic [TAG_W-1:0]            pushTag,
  output logic                        reqErr,
  output logic                        dispValid,
  output logic [TAG_W-1:0]            dispTag,
  output logic [RANK_W-1:0]           dispRank,
  output logic                        dispWrite,
  output logic                        cmplValid,
  output logic [TAG_W-1:0]            cmplTag
);
  // Scoreboard, one bit per tag
  logic [DEPTH-1:0] tagLive, tagWrite, tagLate, tagData, tagQueued, earlyPend;
  logic [RANK_W-1:0] tagRank [DEPTH];
  // Rank occupancy
  logic [RANKS-1:0] rankBusy;
  logic [TAG_W-1:0] rankTag [RANKS];

  logic accept, dataHit, doneHit, doneCmpl;
  logic [TAG_W-1:0] doneTag;
  assign accept  = reqValid && !tagLive[reqTag];
  assign dataHit = dataValid && tagLive[dataTag] && tagWrite[dataTag] && !tagData[dataTag];
  assign doneHit = doneValid && rankBusy[doneRank];
  assign doneTag = rankTag[doneRank];
  assign doneCmpl = doneHit && (tagLate[doneTag] || earlyPend[doneTag]);

  // Oldest eligible entry of the active list
  logic selFound;
  logic [IDX_W-1:0] selIdx;
  logic [TAG_W-1:0] selTag;
  always_comb begin
    selFound = 1'b0;
    selIdx   = '0;
    selTag   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!selFound && CNT_W'(i) < count && !rankBusy[tagRank[entries[i]]]
          && (!tagWrite[entries[i]] || tagData[entries[i]])) begin
        selFound = 1'b1;
        selIdx   = IDX_W'(i);
        selTag   = entries[i];
      end
    end
  end

  // Lowest-numbered pending early completion
  logic pendAny;
  logic [TAG_W-1:0] pendTag;
  always_comb begin
    pendAny = 1'b0;
    pendTag = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (earlyPend[i]) begin
        pendAny = 1'b1;
        pendTag = TAG_W'(i);
      end
    end
  end

  assign strobe.push = accept;
  assign strobe.pop  = selFound;
  assign popIdx      = selIdx;
  assign pushTag     = reqTag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tagLive <= '0; tagWrite <= '0; tagLate <= '0;
      tagData <= '0; tagQueued <= '0; earlyPend <= '0;
      rankBusy <= '0;
      for (int i = 0; i < DEPTH; i++) tagRank[i] <= '0;
      for (int r = 0; r < RANKS; r++) rankTag[r] <= '0;
      reqErr <= 1'b0; dispValid <= 1'b0; dispTag <= '0; dispRank <= '0;
      dispWrite <= 1'b0; cmplValid <= 1'b0; cmplTag <= '0;
    end else begin
      reqErr <= reqValid && !accept;
      if (accept) begin
        tagLive[reqTag]   <= 1'b1;
        tagWrite[reqTag]  <= reqWrite;
        tagLate[reqTag]   <= !reqWrite || !earlyMode;
        tagData[reqTag]   <= 1'b0;
        tagQueued[reqTag] <= 1'b1;
        earlyPend[reqTag] <= 1'b0;
        tagRank[reqTag]   <= reqRank;
      end
      if (dataHit) begin
        tagData[dataTag] <= 1'b1;
        if (!tagLate[dataTag]) earlyPend[dataTag] <= 1'b1;
      end
      dispValid <= selFound;
      if (selFound) begin
        tagQueued[selTag]         <= 1'b0;
        rankBusy[tagRank[selTag]] <= 1'b1;
        rankTag[tagRank[selTag]]  <= selTag;
        dispTag   <= selTag;
        dispRank  <= tagRank[selTag];
        dispWrite <= tagWrite[selTag];
      end
      if (doneHit) begin
        rankBusy[doneRank] <= 1'b0;
        tagLive[doneTag]   <= 1'b0;
        earlyPend[doneTag] <= 1'b0;
      end
      if (doneCmpl) begin
        cmplValid <= 1'b1;
        cmplTag   <= doneTag;
      end else if (pendAny) begin
        cmplValid <= 1'b1;
        cmplTag   <= pendTag;
        earlyPend[pendTag] <= 1'b0;
      end else begin
        cmplValid <= 1'b0;
      end
    end
  end

  assert_list_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count == CNT_W'($countones(tagQueued)));
  assert_done_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    doneHit |-> (tagLive[doneTag] && !tagQueued[doneTag]));
  assert_disp_holds_rank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dispValid |-> (rankBusy[dispRank] && rankTag[dispRank] == dispTag));
  assert_write_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dispValid && dispWrite) |-> tagData[dispTag]);
  assert_err_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reqErr |-> $past(reqValid));
  assert_cmpl_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pendAny && !doneCmpl) |-> tagLive[pendTag]);
endmodule

// File: rtl/rank_req_sched.sv
module rank_req_sched
  import sched_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int RANK_W = 4,
  localparam int DEPTH = 1 << TAG_W,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              earlyMode,
  input  logic              reqValid,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [RANK_W-1:0] reqRank,
  input  logic              reqWrite,
  output logic              reqErr,
  input  logic              dataValid,
  input  logic [TAG_W-1:0]  dataTag,
  input  logic              doneValid,
  input  logic [RANK_W-1:0] doneRank,
  output logic              dispValid,
  output logic [TAG_W-1:0]  dispTag,
  output logic [RANK_W-1:0] dispRank,
  output logic              dispWrite,
  output logic              cmplValid,
  output logic [TAG_W-1:0]  cmplTag
);
  listStrobe_t listStrobe;
  logic [IDX_W-1:0] popIdx;
  logic [TAG_W-1:0] pushTag;
  logic [DEPTH-1:0][TAG_W-1:0] entries;
  logic [CNT_W-1:0] count;

  sched_list #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_list (
    .clk(clk), .rst_n(rst_n), .strobe(listStrobe), .pushTag(pushTag),
    .popIdx(popIdx), .entries(entries), .count(count));

  sched_ctrl #(.TAG_W(TAG_W), .RANK_W(RANK_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .earlyMode(earlyMode),
    .reqValid(reqValid), .reqTag(reqTag), .reqRank(reqRank), .reqWrite(reqWrite),
    .dataValid(dataValid), .dataTag(dataTag),
    .doneValid(doneValid), .doneRank(doneRank),
    .entries(entries), .count(count),
    .strobe(listStrobe), .popIdx(popIdx), .pushTag(pushTag),
    .reqErr(reqErr), .dispValid(dispValid), .dispTag(dispTag),
    .dispRank(dispRank), .dispWrite(dispWrite),
    .cmplValid(cmplValid), .cmplTag(cmplTag));
endmodule

// File: tb/rank_req_sched_bench.sv
module rank_req_sched_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic earlyMode = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [5:0] reqTag = '0;
  logic [3:0] reqRank = '0;
  logic dataValid = 1'b0;
  logic [5:0] dataTag = '0;
  logic doneValid = 1'b0;
  logic [3:0] doneRank = '0;
  logic reqErr, dispValid, dispWrite, cmplValid;
  logic [5:0] dispTag, cmplTag;
  logic [3:0] dispRank;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rank_req_sched u_rank_req_sched (
    .clk(clk), .rst_n(rst_n), .earlyMode(earlyMode),
    .reqValid(reqValid), .reqTag(reqTag), .reqRank(reqRank), .reqWrite(reqWrite),
    .reqErr(reqErr), .dataValid(dataValid), .dataTag(dataTag),
    .doneValid(doneValid), .doneRank(doneRank),
    .dispValid(dispValid), .dispTag(dispTag), .dispRank(dispRank), .dispWrite(dispWrite),
    .cmplValid(cmplValid), .cmplTag(cmplTag));

  typedef struct packed {
    logic       wr;
    logic [3:0] rank;
    logic [5:0] tag;
  } vec_t;
  // Each vector: issue alone, expect dispatch to (tag, rank), then completion of tag
  localparam vec_t VECS [6] = '{
    '{1'b0, 4'd0,  6'd1},
    '{1'b1, 4'd3,  6'd2},
    '{1'b0, 4'd15, 6'd63},
    '{1'b1, 4'd8,  6'd0},
    '{1'b0, 4'd0,  6'd1},
    '{1'b1, 4'd15, 6'd33}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendReq(input logic [5:0] t, input logic [3:0] r, input logic w);
    reqValid = 1'b1; reqTag = t; reqRank = r; reqWrite = w;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    chk("reset dispValid", dispValid, 0);
    chk("reset cmplValid", cmplValid, 0);
    chk("reset reqErr", reqErr, 0);

    // Table walk, late policy: R4 R5 R6 R7
    for (int i = 0; i < 6; i++) begin
      sendReq(VECS[i].tag, VECS[i].rank, VECS[i].wr);
      tick(); reqValid = 1'b0;
      if (VECS[i].wr) begin
        dataValid = 1'b1; dataTag = VECS[i].tag;
        tick(); dataValid = 1'b0;
        chk("R4 write waits one more cycle", dispValid, 0);
        chk("R7 no completion on data", cmplValid, 0);
      end
      tick();
      chk("R5 dispatch valid", dispValid, 1);
      chk("R5 dispatch tag", dispTag, VECS[i].tag);
      chk("R5 dispatch rank", dispRank, VECS[i].rank);
      chk("R5 dispatch kind", dispWrite, VECS[i].wr);
      doneValid = 1'b1; doneRank = VECS[i].rank;
      tick(); doneValid = 1'b0;
      chk("R6 R7 completion valid", cmplValid, 1);
      chk("R6 R7 completion tag", cmplTag, VECS[i].tag);
    end

    // R1 duplicate tag in the next cycle
    sendReq(6'd5, 4'd0, 1'b0);
    tick(); sendReq(6'd5, 4'd1, 1'b0);
    tick(); reqValid = 1'b0;
    chk("R1 duplicate flagged", reqErr, 1);
    chk("R1 original dispatched", dispTag, 5);
    tick();
    chk("R1 duplicate not dispatched", dispValid, 0);
    chk("R1 error is a pulse", reqErr, 0);
    doneValid = 1'b1; doneRank = 4'd0;
    tick(); doneRank = 4'd1;
    chk("R1 original completes", cmplTag, 5);
    tick(); doneValid = 1'b0;
    chk("R10 done on idle rank ignored", cmplValid, 0);

    // R3 busy rank passed by younger, R2 oldest first
    sendReq(6'd10, 4'd2, 1'b0);
    tick(); sendReq(6'd11, 4'd2, 1'b0);
    tick(); sendReq(6'd13, 4'd2, 1'b0);
    chk("R3 first to rank 2", dispTag, 10);
    tick(); sendReq(6'd12, 4'd3, 1'b0);
    tick(); reqValid = 1'b0;
    chk("R3 busy rank holds request", dispValid, 0);
    tick();
    chk("R3 younger to idle rank passes", dispTag, 12);
    chk("R3 rank of younger", dispRank, 3);
    doneValid = 1'b1; doneRank = 4'd2;
    tick(); doneValid = 1'b0;
    chk("R6 rank 2 completion", cmplTag, 10);
    tick();
    chk("R2 oldest waiting goes first", dispTag, 11);
    doneValid = 1'b1; doneRank = 4'd2;
    tick(); doneValid = 1'b0;
    chk("R2 second completion", cmplTag, 11);
    tick();
    chk("R2 youngest last", dispTag, 13);
    doneValid = 1'b1; doneRank = 4'd2;
    tick(); doneRank = 4'd3;
    chk("R6 tag 13 completes", cmplTag, 13);
    tick(); doneValid = 1'b0;
    chk("R6 tag 12 completes", cmplTag, 12);

    // R4 R7 write without data, late policy
    earlyMode = 1'b0;
    sendReq(6'd30, 4'd5, 1'b1);
    tick(); reqValid = 1'b0;
    tick(); tick(); tick();
    chk("R4 write without data not dispatched", dispValid, 0);
    dataValid = 1'b1; dataTag = 6'd30;
    tick(); dataValid = 1'b0;
    tick();
    chk("R4 write dispatched after data", dispTag, 30);
    chk("R7 no early completion", cmplValid, 0);
    doneValid = 1'b1; doneRank = 4'd5;
    tick(); doneValid = 1'b0;
    chk("R7 late completion tag", cmplTag, 30);

    // R8 early policy, latched at acceptance
    earlyMode = 1'b1;
    sendReq(6'd31, 4'd6, 1'b1);
    tick(); reqValid = 1'b0; earlyMode = 1'b0;
    dataValid = 1'b1; dataTag = 6'd31;
    tick(); dataValid = 1'b0;
    tick();
    chk("R8 early completion valid", cmplValid, 1);
    chk("R8 early completion tag", cmplTag, 31);
    chk("R8 dispatch of early write", dispTag, 31);
    sendReq(6'd31, 4'd7, 1'b0);
    tick(); reqValid = 1'b0;
    chk("R8 tag held until done", reqErr, 1);
    tick();
    chk("R8 rejected reuse not dispatched", dispValid, 0);
    doneValid = 1'b1; doneRank = 4'd6;
    tick(); doneValid = 1'b0;
    chk("R8 no second completion", cmplValid, 0);
    sendReq(6'd31, 4'd7, 1'b0);
    tick(); reqValid = 1'b0;
    chk("R8 tag free after done", reqErr, 0);
    tick();
    chk("R8 reused tag dispatched", dispRank, 7);
    doneValid = 1'b1; doneRank = 4'd7;
    tick(); doneValid = 1'b0;
    chk("R6 reused tag completes", cmplTag, 31);

    // R9 collision of done completion and early completion
    sendReq(6'd40, 4'd7, 1'b0);
    tick(); earlyMode = 1'b1; sendReq(6'd41, 4'd8, 1'b1);
    tick(); reqValid = 1'b0; earlyMode = 1'b0;
    chk("R9 setup dispatch", dispTag, 40);
    dataValid = 1'b1; dataTag = 6'd41;
    tick(); dataValid = 1'b0;
    doneValid = 1'b1; doneRank = 4'd7;
    tick(); doneValid = 1'b0;
    chk("R9 done completion first", cmplTag, 40);
    chk("R9 write dispatched", dispTag, 41);
    tick();
    chk("R9 early completion next valid", cmplValid, 1);
    chk("R9 early completion next tag", cmplTag, 41);
    doneValid = 1'b1; doneRank = 4'd8;
    tick(); doneValid = 1'b0;
    chk("R9 no repeat at done", cmplValid, 0);

    // R10 data for a tag that is not outstanding
    dataValid = 1'b1; dataTag = 6'd50;
    tick(); dataValid = 1'b0;
    earlyMode = 1'b1; sendReq(6'd50, 4'd9, 1'b1);
    tick(); reqValid = 1'b0; earlyMode = 1'b0;
    tick(); tick();
    chk("R10 stale data ignored, no dispatch", dispValid, 0);
    chk("R10 stale data ignored, no completion", cmplValid, 0);
    dataValid = 1'b1; dataTag = 6'd50;
    tick(); dataValid = 1'b0;
    tick();
    chk("R10 real data completes", cmplTag, 50);
    doneValid = 1'b1; doneRank = 4'd9;
    tick(); doneValid = 1'b0;

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule